// File: doc/BRIEF.md
# Video data-enable recovery from sync edges

This block takes a parallel RGB video stream that carries only a pixel clock, horizontal sync, vertical sync and 24 bits of colour, with no separate data-enable line. It rebuilds the data-enable flag and the pixel column and row of each active sample. It does this by counting pixel clocks from each horizontal sync rising edge and lines from each vertical sync rising edge, against fixed porch and pulse widths. The defaults describe a 1280x720, 60 Hz raster: 1650 clocks per line and 750 lines per frame, with a pixel clock of about 74.25 MHz. All logic runs on the incoming pixel clock.

The colour and sync inputs pass through the same single register stage as the recovered data-enable and positions, so a downstream encoder sees one aligned bundle. A lock flag reports whether the measured raster matches the programmed one. Data-enable is held low until one full frame has been measured clean, and it drops again as soon as any line or frame length departs from the expected values.

Top module: `drec_video_de_recover`

## Requirements
- R1: The horizontal position is reset by an hsync rising edge, meaning a clock at which hsync is sampled high after being sampled low at the previous clock. That sample is position 0, and positions H_SYNC+H_BP through H_SYNC+H_BP+H_ACTIVE-1 are active columns. Within an active line, x_o counts up by one per clock from 0.
- R2: The line index is reset at an hsync rising edge where vsync is high and vsync was low at the previous hsync rising edge. Lines V_SYNC+V_BP through V_SYNC+V_BP+V_ACTIVE-1 from that line are active, and y_o holds steady across one active line.
- R3: de_o, x_o, y_o, rgb_o, hs_o and vs_o each show the input sample from the previous clock, through exactly one register stage, so all of them stay cycle-aligned.
- R4: While de_o is high, x_o and y_o give the zero-based column and row within the active area. While de_o is low, both read 0.
- R5: Measurement starts at the first frame start after reset. lock_o rises at the frame start that ends a frame in which every line lasted H_TOTAL clocks and which held exactly V_TOTAL lines.
- R6: A line that ends, at the next hsync rising edge, after fewer than H_TOTAL clocks clears lock_o at that edge.
- R7: A line that is still running when its count reaches H_TOTAL clears lock_o at that clock.
- R8: A frame that reaches a line index of V_TOTAL before a new frame start clears lock_o at the hsync rising edge that begins that line.
- R9: de_o is never high while lock_o is low.
- R10: An asynchronous active-low reset clears de_o, lock_o, x_o, y_o, rgb_o, hs_o and vs_o at once.
- R11: After a loss of lock, the frame that begins after the faulty frame ends is measured afresh, and lock_o returns at its end if that frame is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| rgb_i | input | 3*COLOR_W | Colour sample, red in the top byte, blue in the bottom byte |
| de_o | output | 1 | Recovered data-enable |
| hs_o | output | 1 | Horizontal sync aligned to de_o |
| vs_o | output | 1 | Vertical sync aligned to de_o |
| rgb_o | output | 3*COLOR_W | Colour aligned to de_o |
| x_o | output | clog2(H_ACTIVE) | Active column, 0 outside active video |
| y_o | output | clog2(V_ACTIVE) | Active row, 0 outside active video |
| lock_o | output | 1 | Raster timing matches the programmed geometry |

## Verification
The hardest states to reach from the ports are the timing faults, because a well-formed raster never produces them. The bench drives a reduced-size raster through the same parameters and builds every frame from a line table. This lets it insert a shortened active line, an over-long blanking line, or an extra line at the end of a frame. After each fault it keeps driving clean frames, so the clearing of lock, the frame with data-enable suppressed, and the return of lock are all observed cycle by cycle.

// File: rtl/drec_pkg.sv
package drec_pkg;

  typedef enum logic [1:0] {
    LK_HUNT   = 2'd0,
    LK_CHECK  = 2'd1,
    LK_LOCKED = 2'd2
  } lk_state_e;

endpackage

// File: rtl/drec_sync_edge.sv
module drec_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_i,
  input  logic vs_i,
  output logic hs_rise_o,
  output logic frame_start_o
);

  logic hs_q, hs_d;
  logic vs_line_q, vs_line_d;

  always_comb begin
    hs_d          = hs_i;
    hs_rise_o     = hs_i & ~hs_q;
    frame_start_o = hs_rise_o & vs_i & ~vs_line_q;
    vs_line_d     = hs_rise_o ? vs_i : vs_line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q      <= 1'b0;
      vs_line_q <= 1'b0;
    end else begin
      hs_q      <= hs_d;
      vs_line_q <= vs_line_d;
    end
  end

endmodule

// File: rtl/drec_span_counter.sv
module drec_span_counter #(
  parameter int TOTAL  = 1650,
  parameter int OFFSET = 260,
  parameter int ACTIVE = 1280,
  parameter int IW     = $clog2(ACTIVE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          restart_i,
  output logic          win_o,
  output logic [IW-1:0] idx_o,
  output logic          len_ok_o,
  output logic          overrun_o
);

  localparam int            CW   = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);
  localparam logic [CW-1:0] SAT  = CW'(TOTAL);
  localparam logic [CW-1:0] LO   = CW'(OFFSET);
  localparam logic [CW-1:0] HI   = CW'(OFFSET + ACTIVE);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i)
      cnt_d = '0;
    else if (step_i && (cnt_q != SAT))
      cnt_d = CW'(cnt_q + 1'b1);
    else
      cnt_d = cnt_q;
    win_o     = (cnt_d >= LO) && (cnt_d < HI);
    idx_o     = IW'(cnt_d - LO);
    len_ok_o  = (cnt_q == LAST);
    overrun_o = step_i & ~restart_i & (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/drec_lock_ctrl.sv
module drec_lock_ctrl
  import drec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hs_rise_i,
  input  logic frame_start_i,
  input  logic h_len_ok_i,
  input  logic v_len_ok_i,
  input  logic h_over_i,
  input  logic v_over_i,
  output logic lock_nxt_o,
  output logic lock_o
);

  lk_state_e st_q, st_d;
  logic      clean_q, clean_d;
  logic      line_bad;

  always_comb begin
    st_d     = st_q;
    clean_d  = clean_q;
    line_bad = (hs_rise_i & ~h_len_ok_i) | h_over_i | v_over_i;
    if (st_q == LK_HUNT) begin
      if (frame_start_i) begin
        st_d    = LK_CHECK;
        clean_d = 1'b1;
      end
    end else begin
      if (frame_start_i) begin
        st_d    = (clean_q & ~line_bad & v_len_ok_i) ? LK_LOCKED : LK_CHECK;
        clean_d = 1'b1;
      end else if (line_bad) begin
        st_d    = LK_CHECK;
        clean_d = 1'b0;
      end
    end
    lock_nxt_o = (st_d == LK_LOCKED);
    lock_o     = (st_q == LK_LOCKED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LK_HUNT;
      clean_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      clean_q <= clean_d;
    end
  end

endmodule

// File: rtl/drec_out_stage.sv
module drec_out_stage #(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_d,
  input  logic [XW-1:0] x_d,
  input  logic [YW-1:0] y_d,
  input  logic [PW-1:0] rgb_d,
  input  logic          hs_d,
  input  logic          vs_d,
  output logic          de_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic [PW-1:0] rgb_o,
  output logic          hs_o,
  output logic          vs_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_o  <= 1'b0;
      x_o   <= '0;
      y_o   <= '0;
      rgb_o <= '0;
      hs_o  <= 1'b0;
      vs_o  <= 1'b0;
    end else begin
      de_o  <= de_d;
      x_o   <= x_d;
      y_o   <= y_d;
      rgb_o <= rgb_d;
      hs_o  <= hs_d;
      vs_o  <= vs_d;
    end
  end

endmodule

// File: rtl/drec_video_de_recover.sv
module drec_video_de_recover #(
  parameter int H_ACTIVE = 1280,
  parameter int H_FP     = 110,
  parameter int H_SYNC   = 40,
  parameter int H_BP     = 220,
  parameter int V_ACTIVE = 720,
  parameter int V_FP     = 5,
  parameter int V_SYNC   = 5,
  parameter int V_BP     = 20,
  parameter int COLOR_W  = 8,
  localparam int PW      = 3 * COLOR_W,
  localparam int XW      = $clog2(H_ACTIVE),
  localparam int YW      = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_i,
  input  logic          vs_i,
  input  logic [PW-1:0] rgb_i,
  output logic          de_o,
  output logic          hs_o,
  output logic          vs_o,
  output logic [PW-1:0] rgb_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          lock_o
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int H_OFF   = H_SYNC + H_BP;
  localparam int V_OFF   = V_SYNC + V_BP;

  logic          hs_rise, frame_start;
  logic          h_win, v_win;
  logic [XW-1:0] h_idx;
  logic [YW-1:0] v_idx;
  logic          h_len_ok, v_len_ok, h_over, v_over;
  logic          lock_nxt;
  logic          de_d;
  logic [XW-1:0] x_d;
  logic [YW-1:0] y_d;

  drec_sync_edge edge_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_i          (hs_i),
    .vs_i          (vs_i),
    .hs_rise_o     (hs_rise),
    .frame_start_o (frame_start)
  );

  drec_span_counter #(
    .TOTAL  (H_TOTAL),
    .OFFSET (H_OFF),
    .ACTIVE (H_ACTIVE),
    .IW     (XW)
  ) hcnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (1'b1),
    .restart_i (hs_rise),
    .win_o     (h_win),
    .idx_o     (h_idx),
    .len_ok_o  (h_len_ok),
    .overrun_o (h_over)
  );

  drec_span_counter #(
    .TOTAL  (V_TOTAL),
    .OFFSET (V_OFF),
    .ACTIVE (V_ACTIVE),
    .IW     (YW)
  ) vcnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (hs_rise),
    .restart_i (frame_start),
    .win_o     (v_win),
    .idx_o     (v_idx),
    .len_ok_o  (v_len_ok),
    .overrun_o (v_over)
  );

  drec_lock_ctrl lock_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_rise_i     (hs_rise),
    .frame_start_i (frame_start),
    .h_len_ok_i    (h_len_ok),
    .v_len_ok_i    (v_len_ok),
    .h_over_i      (h_over),
    .v_over_i      (v_over),
    .lock_nxt_o    (lock_nxt),
    .lock_o        (lock_o)
  );

  always_comb begin
    de_d = h_win & v_win & lock_nxt;
    x_d  = de_d ? h_idx : '0;
    y_d  = de_d ? v_idx : '0;
  end

  drec_out_stage #(
    .XW (XW),
    .YW (YW),
    .PW (PW)
  ) out_i (
    .clk   (clk),
    .rst_n (rst_n),
    .de_d  (de_d),
    .x_d   (x_d),
    .y_d   (y_d),
    .rgb_d (rgb_i),
    .hs_d  (hs_i),
    .vs_d  (vs_i),
    .de_o  (de_o),
    .x_o   (x_o),
    .y_o   (y_o),
    .rgb_o (rgb_o),
    .hs_o  (hs_o),
    .vs_o  (vs_o)
  );

endmodule

// File: rtl/drec_video_de_recover_chk.sv
module drec_video_de_recover_chk #(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_i,
  input logic          vs_i,
  input logic [PW-1:0] rgb_i,
  input logic          de_o,
  input logic          hs_o,
  input logic          vs_o,
  input logic [PW-1:0] rgb_o,
  input logic [XW-1:0] x_o,
  input logic [YW-1:0] y_o,
  input logic          lock_o
);

  p_de_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> lock_o);

  p_idle_pos_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> (x_o == '0 && y_o == '0));

  p_first_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_o) |-> (x_o == '0));

  p_col_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o && $past(de_o)) |-> (x_o == XW'($past(x_o) + 1'b1)));

  p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o && $past(de_o)) |-> (y_o == $past(y_o)));

  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rgb_o == $past(rgb_i) && hs_o == $past(hs_i) && vs_o == $past(vs_i)));

endmodule

bind drec_video_de_recover drec_video_de_recover_chk #(
  .XW (XW),
  .YW (YW),
  .PW (PW)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .hs_i   (hs_i),
  .vs_i   (vs_i),
  .rgb_i  (rgb_i),
  .de_o   (de_o),
  .hs_o   (hs_o),
  .vs_o   (vs_o),
  .rgb_o  (rgb_o),
  .x_o    (x_o),
  .y_o    (y_o),
  .lock_o (lock_o)
);

// File: tb/drec_video_de_recover_tb_top.sv
module drec_video_de_recover_tb_top;

  localparam int HA = 16, HFP = 4, HS = 3, HBP = 5;
  localparam int VA = 6,  VFP = 1, VS = 2, VBP = 3;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int HOFF = HS + HBP;
  localparam int VOFF = VS + VBP;
  localparam int XW = $clog2(HA);
  localparam int YW = $clog2(VA);

  typedef struct {
    bit         de;
    int         x;
    int         y;
    logic [23:0] rgb;
    bit         hs;
    bit         vs;
    bit         lock;
    int         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hs_i = 1'b0;
  logic          vs_i = 1'b0;
  logic [23:0]   rgb_i = '0;
  logic          de_o, hs_o, vs_o, lock_o;
  logic [23:0]   rgb_o;
  logic [XW-1:0] x_o;
  logic [YW-1:0] y_o;

  int n_chk = 0;
  int n_fail = 0;
  exp_t q[$];

  // model state
  bit m_lock = 0, m_have = 0, m_clean = 0;
  int m_last_len = 0, m_lines = 0, fcnt = 0;

  always #4 clk = ~clk;

  drec_video_de_recover #(
    .H_ACTIVE (HA), .H_FP (HFP), .H_SYNC (HS), .H_BP (HBP),
    .V_ACTIVE (VA), .V_FP (VFP), .V_SYNC (VS), .V_BP (VBP),
    .COLOR_W  (8)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .hs_i (hs_i), .vs_i (vs_i), .rgb_i (rgb_i),
    .de_o (de_o), .hs_o (hs_o), .vs_o (vs_o), .rgb_o (rgb_o),
    .x_o (x_o), .y_o (y_o), .lock_o (lock_o)
  );

  function automatic string tag_name(int t);
    case (t)
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      11: return "R11";
      default: return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  task automatic model_reset();
    m_lock = 0; m_have = 0; m_clean = 0; m_last_len = 0; m_lines = 0;
  endtask

  // driver: one frame, optionally with one odd-length line
  task automatic drive_frame(int n_lines, int odd_line, int odd_len, int tag);
    for (int l = 0; l < n_lines; l++) begin
      int len;
      len = (l == odd_line) ? odd_len : HT;
      for (int p = 0; p < len; p++) begin
        exp_t it;
        bit act;
        @(negedge clk);
        hs_i  = (p < HS);
        vs_i  = (l < VS);
        rgb_i = {8'(fcnt * 37 + l * 11), 8'(l * 5 + p), 8'(p * 3 + fcnt)};
        if (p == 0 && l == 0) begin
          m_lock  = m_have && m_clean && (m_last_len == HT) && (m_lines == VT);
          m_have  = 1;
          m_clean = 1;
        end else if (p == 0) begin
          if (m_last_len != HT || l == VT) begin
            m_lock = 0; m_clean = 0;
          end
        end
        if (p == HT) begin
          m_lock = 0; m_clean = 0;
        end
        act     = (l >= VOFF) && (l < VOFF + VA) && (p >= HOFF) && (p < HOFF + HA);
        it.de   = act && m_lock;
        it.x    = it.de ? p - HOFF : 0;
        it.y    = it.de ? l - VOFF : 0;
        it.rgb  = rgb_i;
        it.hs   = hs_i;
        it.vs   = vs_i;
        it.lock = m_lock;
        it.tag  = tag;
        q.push_back(it);
      end
      m_last_len = len;
    end
    m_lines = n_lines;
    fcnt++;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(de_o == e.de, "R1 R2 R9", "de_o", int'(de_o), int'(e.de));
        check(int'(x_o) == e.x, "R1 R4", "x_o", int'(x_o), e.x);
        check(int'(y_o) == e.y, "R2 R4", "y_o", int'(y_o), e.y);
        check(rgb_o == e.rgb && hs_o == e.hs && vs_o == e.vs, "R3", "rgb/hs/vs",
              int'({rgb_o, hs_o, vs_o}), int'({e.rgb, e.hs, e.vs}));
        check(lock_o == e.lock, tag_name(e.tag), "lock_o", int'(lock_o), int'(e.lock));
      end
    end
  end

  initial begin
    #(64'd8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    check(de_o == 1'b0 && lock_o == 1'b0, "R10", "de/lock in reset", int'({de_o, lock_o}), 0);
    check(x_o == '0 && y_o == '0 && rgb_o == '0, "R10", "pos/rgb in reset", int'(x_o), 0);
    rst_n = 1'b1;
    model_reset();
    drive_frame(VT, -1, HT, 5);      // first frame measured, no lock
    drive_frame(VT, -1, HT, 5);      // locked
    drive_frame(VT, 7, HT - 6, 6);   // short active line R6
    drive_frame(VT, -1, HT, 11);     // measured again
    drive_frame(VT, -1, HT, 11);     // lock back R11
    drive_frame(VT + 1, -1, HT, 8);  // extra line R8
    drive_frame(VT, -1, HT, 11);
    drive_frame(VT, -1, HT, 11);
    drive_frame(VT, 3, HT + 3, 7);   // long blank line R7
    drive_frame(VT, -1, HT, 11);
    drive_frame(VT, -1, HT, 11);
    drive_frame(VT, 0, 2 * HOFF, 5); // partial line, ensures lock held then
    @(negedge clk);
    hs_i = 1'b0; vs_i = 1'b0; rgb_i = '0;
    repeat (2) @(negedge clk);
    // R10: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check(lock_o == 1'b0 && de_o == 1'b0, "R10", "lock/de after reset", int'({lock_o, de_o}), 0);
    check(x_o == '0 && y_o == '0 && hs_o == 1'b0 && vs_o == 1'b0, "R10", "outputs after reset",
          int'({hs_o, vs_o}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    drive_frame(VT, -1, HT, 5);
    drive_frame(VT, -1, HT, 5);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule